// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the time of day and the calendar date as packed binary-coded decimal in eight byte-wide registers. A single-cycle tick input, normally made by a divider that runs at one pulse per second, advances the seconds. Carries ripple through minutes, hours, day of week, date, month and year within the same clock cycle. Month lengths follow the calendar, and February takes 29 days when the two-digit year is a multiple of four.

A byte-wide register port sits beside the counters so that a bus front end can set or read any field. Reads are combinational from the address. A write lands on the next clock edge and takes precedence over a tick in that cycle. The eighth register is a free byte for the control bits of neighbouring logic, and its value is always driven on a dedicated output. Bit 7 of the seconds register freezes all counting while it is set.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, addresses 0..7 read 00, 00, 00, 01, 01, 01, 00, 00, and `ctrl_o` is 00.
- R2: The seconds (address 0, bits 6:0) and minutes (address 1) count 00..59 in BCD with tens in bits 6:4. The units digit rolls from 9 to 0 with tens+1, and 59 wraps to 00 with a carry into the next field.
- R3: The hours (address 2) count 00..23 in BCD, tens in bits 5:4. 23 wraps to 00, and that wrap advances both the day of week and the date.
- R4: The day of week (address 3, bits 2:0) counts 01..07. From 07 it wraps to 01 at midnight, independently of the date.
- R5: The date (address 4) wraps to 01 and advances the month when it is at or above the month length: 30 for months 04, 06, 09 and 11, and 31 for the other months except 02.
- R6: February (month 02) has 29 days when the BCD year value is divisible by 4 (00, 04 ... 96) and 28 days otherwise.
- R7: The month (address 5) counts 01..12, and its wrap from 12 to 01 advances the year (address 6), which counts 00..99 and wraps to 00.
- R8: While bit 7 of address 0 is 1, ticks change no register. The bit is kept until it is rewritten.
- R9: A write stores `wdata_i` at `addr_i` on the clock edge with unused bits forced to 0. The masks are: 0 FF, 1 7F, 2 3F, 3 07, 4 3F, 5 1F, 6 FF, 7 FF. A tick in the same cycle is dropped for every field.
- R10: All eight bits of address 7 are stored, and `ctrl_o` shows them from the edge that writes them.
- R11: Each accepted tick advances the seconds by exactly one. With no tick and no write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle advance pulse, one per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for both reads and writes |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read of the addressed register |
| ctrl_o | output | DATA_W | Current contents of the control register |

## Verification
The hardest condition to reach from the ports is a full carry from seconds to the year, such as 23:59:59 on 31 December of year 99, or a leap-day boundary. Reaching either by counting would take months of ticks. The stimulus therefore writes each field to the value just before a boundary and then issues one tick. A random phase mixes legal writes, including the stop bit and out-of-range dates, with ticks, while a behavioural calendar model tracks every register each cycle.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   localparam int NUM_REGS   = 8;
   localparam int NUM_FIELDS = 7;

   typedef enum logic [2:0] {
      REG_SEC  = 3'd0,
      REG_MIN  = 3'd1,
      REG_HOUR = 3'd2,
      REG_DOW  = 3'd3,
      REG_DATE = 3'd4,
      REG_MON  = 3'd5,
      REG_YEAR = 3'd6,
      REG_CTRL = 3'd7
   } rtc_reg_e;

   // bits kept on a write; the rest read back as zero
   function automatic logic [7:0] keep_mask(input int idx);
      case (idx)
         0:       return 8'hFF;
         1:       return 8'h7F;
         2:       return 8'h3F;
         3:       return 8'h07;
         4:       return 8'h3F;
         5:       return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   // value a counting field wraps to (and resets to)
   function automatic logic [7:0] wrap_value(input int idx);
      case (idx)
         3, 4, 5: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

   // fixed top value of a counting field; the date top is computed
   function automatic logic [7:0] top_value(input int idx);
      case (idx)
         0, 1:    return 8'h59;
         2:       return 8'h23;
         3:       return 8'h07;
         4:       return 8'h31;
         5:       return 8'h12;
         default: return 8'h99;
      endcase
   endfunction

   // field whose wrap enables field idx (field 0 is enabled by the tick)
   function automatic int carry_source(input int idx);
      case (idx)
         1:       return 0;
         2:       return 1;
         3:       return 2;
         4:       return 2;
         5:       return 4;
         6:       return 5;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
// One packed-BCD counting stage: adds one when enabled, wraps at or above top.
module rtc_bcd_field #(
   parameter int         FIELD_W = 8,
   parameter logic [7:0] FIRST   = 8'h00
) (
   input  logic [FIELD_W-1:0] cur_i,
   input  logic [FIELD_W-1:0] top_i,
   input  logic               en_i,
   output logic [FIELD_W-1:0] nxt_o,
   output logic               wrap_o
);
   localparam int DIGIT_W = 4;

   initial begin
      assert (FIELD_W == 2 * DIGIT_W)
         else $error("rtc_bcd_field: FIELD_W must hold two BCD digits");
   end

   logic [DIGIT_W-1:0] units;
   logic [DIGIT_W-1:0] tens;
   logic               at_top;

   assign units  = cur_i[DIGIT_W-1:0];
   assign tens   = cur_i[FIELD_W-1:DIGIT_W];
   assign at_top = (cur_i >= top_i);
   assign wrap_o = en_i & at_top;

   always_comb begin
      if (!en_i) begin
         nxt_o = cur_i;
      end else if (at_top) begin
         nxt_o = FIRST[FIELD_W-1:0];
      end else if (units == 4'd9) begin
         nxt_o = {tens + 4'd1, 4'd0};
      end else begin
         nxt_o = {tens, units + 4'd1};
      end
   end
endmodule

// File: rtl/rtc_month_len.sv
// Last date of the current month in packed BCD.
module rtc_month_len #(
   parameter bit LEAP_AUTO = 1'b1
) (
   input  logic [7:0] month_i,
   input  logic [7:0] year_i,
   output logic [7:0] last_o
);
   logic leap;

   generate
      if (LEAP_AUTO) begin : g_leap
         logic [6:0] year_bin;
         assign year_bin = {3'b000, year_i[7:4]} * 7'd10 + {3'b000, year_i[3:0]};
         assign leap     = ((year_bin & 7'd3) == 7'd0);
      end else begin : g_no_leap
         assign leap = 1'b0;
      end
   endgenerate

   always_comb begin
      case (month_i)
         8'h02:                      last_o = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
         default:                    last_o = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import bcd_rtc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter bit LEAP_AUTO = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] ctrl_o
);
   localparam int NREG     = 1 << ADDR_W;
   localparam int STOP_BIT = DATA_W - 1;

   initial begin
      assert (DATA_W == 8) else $error("bcd_rtc_core: DATA_W must be 8");
      assert (NREG == NUM_REGS) else $error("bcd_rtc_core: ADDR_W must give 8 registers");
   end

   logic [NREG-1:0][DATA_W-1:0]       reg_q;
   logic [NUM_FIELDS-1:0]             field_en;
   logic [NUM_FIELDS-1:0]             field_wrap;
   logic [NUM_FIELDS-1:0][DATA_W-1:0] field_cur;
   logic [NUM_FIELDS-1:0][DATA_W-1:0] field_nxt;
   logic [DATA_W-1:0]                 date_last;
   logic                              advance;

   assign advance = tick_i & ~wr_en_i & ~reg_q[REG_SEC][STOP_BIT];

   rtc_month_len #(.LEAP_AUTO(LEAP_AUTO)) u_month_len (
      .month_i (reg_q[REG_MON]),
      .year_i  (reg_q[REG_YEAR]),
      .last_o  (date_last)
   );

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         logic [DATA_W-1:0] top;

         if (i == 0) begin : g_sec
            assign field_cur[i] = {1'b0, reg_q[i][STOP_BIT-1:0]};
            assign field_en[i]  = advance;
         end else begin : g_chain
            assign field_cur[i] = reg_q[i];
            assign field_en[i]  = field_wrap[carry_source(i)];
         end

         if (i == int'(REG_DATE)) begin : g_dyn_top
            assign top = date_last;
         end else begin : g_fix_top
            assign top = top_value(i);
         end

         rtc_bcd_field #(
            .FIELD_W (DATA_W),
            .FIRST   (wrap_value(i))
         ) u_field (
            .cur_i  (field_cur[i]),
            .top_i  (top),
            .en_i   (field_en[i]),
            .nxt_o  (field_nxt[i]),
            .wrap_o (field_wrap[i])
         );
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int r = 0; r < NREG; r++) begin
            reg_q[r] <= (r < NUM_FIELDS) ? wrap_value(r) : '0;
         end
      end else if (wr_en_i) begin
         reg_q[addr_i] <= wdata_i & keep_mask(int'(addr_i));
      end else if (advance) begin
         for (int r = 0; r < NUM_FIELDS; r++) begin
            reg_q[r] <= field_nxt[r];
         end
      end
   end

   assign rdata_o = reg_q[addr_i];
   assign ctrl_o  = reg_q[REG_CTRL];
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input logic                               clk_i,
   input logic                               rst_ni,
   input logic                               tick_i,
   input logic                               wr_en_i,
   input logic [ADDR_W-1:0]                  addr_i,
   input logic [DATA_W-1:0]                  wdata_i,
   input logic [DATA_W-1:0]                  ctrl_o,
   input logic [(1<<ADDR_W)-1:0][DATA_W-1:0] reg_q
);
   logic go;
   assign go = tick_i & ~wr_en_i & ~reg_q[0][7];

   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !wr_en_i) |=> $stable(reg_q)); // R11

   AST_STOP_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !wr_en_i && reg_q[0][7]) |=> $stable(reg_q)); // R8

   AST_SEC_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && reg_q[0][3:0] < 4'd9)
      |=> reg_q[0][3:0] == $past(reg_q[0][3:0]) + 4'd1); // R2

   AST_MIDNIGHT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && reg_q[0] == 8'h59 && reg_q[1] == 8'h59 && reg_q[2] == 8'h23)
      |=> reg_q[2] == 8'h00); // R3

   AST_DOW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && reg_q[0] == 8'h59 && reg_q[1] == 8'h59 && reg_q[2] == 8'h23 && reg_q[3] == 8'h07)
      |=> reg_q[3] == 8'h01); // R4

   AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 3'd7) |=> ctrl_o == $past(wdata_i)); // R10

   AST_WRITE_BEATS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && tick_i && addr_i != 3'd0) |=> $stable(reg_q[0])); // R9
endmodule

bind bcd_rtc_core bcd_rtc_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .tick_i  (tick_i),
   .wr_en_i (wr_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .ctrl_o  (ctrl_o),
   .reg_q   (reg_q)
);

// File: tb/bcd_rtc_core_tb_top.sv
// Delays are in the default time unit (ps): 200 MHz clock = 5000 per period.
module bcd_rtc_core_tb_top;
   localparam int HALF = 2500;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [7:0] ctrl;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R11";
   logic [7:0] m [8];

   always #HALF clk = ~clk;

   bcd_rtc_core dut_i (
      .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .wr_en_i (wr),
      .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .ctrl_o (ctrl)
   );

   function automatic logic [7:0] mask_of(input int r);
      case (r)
         1: return 8'h7F;
         2: return 8'h3F;
         3: return 8'h07;
         4: return 8'h3F;
         5: return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic int b2i(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      logic [7:0] r;
      r[7:4] = 4'((v / 10) % 10);
      r[3:0] = 4'(v % 10);
      return r;
   endfunction

   function automatic int days_in(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic model_step(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
      int s, mi, h, dw, dt, mo, yr;
      if (w) begin
         m[a] = d & mask_of(int'(a));
      end else if (t && !m[0][7]) begin
         s = b2i({1'b0, m[0][6:0]}) + 1;
         mi = b2i(m[1]); h = b2i(m[2]); dw = b2i(m[3]);
         dt = b2i(m[4]); mo = b2i(m[5]); yr = b2i(m[6]);
         if (s >= 60) begin
            s = 0; mi++;
            if (mi >= 60) begin
               mi = 0; h++;
               if (h >= 24) begin
                  h = 0;
                  dw = (dw >= 7) ? 1 : dw + 1;
                  if (dt >= days_in(mo, yr)) begin
                     dt = 1; mo++;
                     if (mo > 12) begin
                        mo = 1; yr = (yr + 1) % 100;
                     end
                  end else begin
                     dt++;
                  end
               end
            end
         end
         m[0] = i2b(s); m[1] = i2b(mi); m[2] = i2b(h); m[3] = i2b(dw);
         m[4] = i2b(dt); m[5] = i2b(mo); m[6] = i2b(yr);
      end
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic sweep();
      for (int r = 0; r < 8; r++) begin
         addr = 3'(r);
         #100;
         check(cur_req, rdata, m[r], $sformatf("reg%0d vs model", r));
      end
      check(cur_req, ctrl, m[7], "ctrl_o vs model");
   endtask

   task automatic step(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      tick = t; wr = w; addr = a; wdata = d;
      @(posedge clk);
      model_step(t, w, a, d);
      #1000;
      tick = 1'b0; wr = 1'b0;
      sweep();
   endtask

   task automatic expect_reg(input int r, input logic [7:0] v, input string req);
      addr = 3'(r);
      #100;
      check(req, rdata, v, $sformatf("reg%0d literal", r));
   endtask

   task automatic set_all(input logic [7:0] s, mi, h, dw, dt, mo, yr);
      step(0, 1, 3'd0, s);  step(0, 1, 3'd1, mi); step(0, 1, 3'd2, h);
      step(0, 1, 3'd3, dw); step(0, 1, 3'd4, dt); step(0, 1, 3'd5, mo);
      step(0, 1, 3'd6, yr);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1000000000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
      m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; m[7] = 8'h00;
      repeat (3) @(posedge clk);
      // R1: reset values, read while reset still held and after release
      cur_req = "R1";
      #1000; sweep();
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1000; sweep();

      // R10: control byte
      cur_req = "R10";
      step(0, 1, 3'd7, 8'hA5);
      check("R10", ctrl, 8'hA5, "ctrl_o after write");
      step(0, 1, 3'd7, 8'h3C);
      check("R10", ctrl, 8'h3C, "ctrl_o second write");

      // R9: unused bits forced to zero
      cur_req = "R9";
      step(0, 1, 3'd3, 8'hFF); expect_reg(3, 8'h07, "R9");
      step(0, 1, 3'd2, 8'hE3); expect_reg(2, 8'h23, "R9");
      step(0, 1, 3'd1, 8'hD9); expect_reg(1, 8'h59, "R9");
      step(0, 1, 3'd5, 8'hF2); expect_reg(5, 8'h12, "R9");
      step(0, 1, 3'd4, 8'hC5); expect_reg(4, 8'h05, "R9");

      // R2: seconds units/tens and minute carry
      cur_req = "R2";
      set_all(8'h08, 8'h00, 8'h10, 8'h02, 8'h10, 8'h03, 8'h21);
      step(1, 0, 3'd0, 8'h00); step(1, 0, 3'd0, 8'h00);
      expect_reg(0, 8'h10, "R2");
      step(0, 1, 3'd0, 8'h59);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(0, 8'h00, "R2"); expect_reg(1, 8'h01, "R2");
      step(0, 1, 3'd1, 8'h59); step(0, 1, 3'd0, 8'h59);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(1, 8'h00, "R2"); expect_reg(2, 8'h11, "R2");

      // R11: idle cycles change nothing, one tick one second
      cur_req = "R11";
      repeat (5) step(0, 0, 3'd0, 8'h00);
      step(1, 0, 3'd0, 8'h00); expect_reg(0, 8'h01, "R11");

      // R3 + R4: midnight, weekday 7 -> 1
      cur_req = "R3";
      set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h05, 8'h06, 8'h10);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(2, 8'h00, "R3"); expect_reg(4, 8'h06, "R3");
      expect_reg(3, 8'h01, "R4");
      cur_req = "R4";
      set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h06, 8'h06, 8'h10);
      step(1, 0, 3'd0, 8'h00); expect_reg(3, 8'h04, "R4");

      // R5: 30- and 31-day months, date above month length
      cur_req = "R5";
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h15);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(4, 8'h01, "R5"); expect_reg(5, 8'h05, "R5");
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h15);
      step(1, 0, 3'd0, 8'h00); expect_reg(4, 8'h31, "R5");
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h11, 8'h15);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(4, 8'h01, "R5"); expect_reg(5, 8'h12, "R5");

      // R6: February in common and leap years
      cur_req = "R6";
      set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(4, 8'h01, "R6"); expect_reg(5, 8'h03, "R6");
      set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(4, 8'h29, "R6"); expect_reg(5, 8'h02, "R6");
      step(0, 1, 3'd0, 8'h59); step(0, 1, 3'd1, 8'h59); step(0, 1, 3'd2, 8'h23);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(4, 8'h01, "R6"); expect_reg(5, 8'h03, "R6");
      set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
      step(1, 0, 3'd0, 8'h00); expect_reg(4, 8'h29, "R6");

      // R7: year carries
      cur_req = "R7";
      set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
      step(1, 0, 3'd0, 8'h00);
      expect_reg(5, 8'h01, "R7"); expect_reg(6, 8'h00, "R7"); expect_reg(4, 8'h01, "R7");
      set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h19);
      step(1, 0, 3'd0, 8'h00); expect_reg(6, 8'h20, "R7");

      // R8: stop bit freezes counting and is retained
      cur_req = "R8";
      set_all(8'hB0, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      repeat (6) step(1, 0, 3'd0, 8'h00);
      expect_reg(0, 8'hB0, "R8"); expect_reg(6, 8'h99, "R8");
      step(0, 1, 3'd0, 8'h30);
      step(1, 0, 3'd0, 8'h00); expect_reg(0, 8'h31, "R8");

      // R9: write wins over a tick in the same cycle
      cur_req = "R9";
      set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      step(1, 1, 3'd7, 8'h5A);
      expect_reg(0, 8'h59, "R9"); expect_reg(2, 8'h23, "R9");
      check("R9", ctrl, 8'h5A, "ctrl_o on tick+write");
      step(1, 1, 3'd0, 8'h12); expect_reg(0, 8'h12, "R9");

      // random mix against the model
      cur_req = "R11";
      for (int n = 0; n < 4000; n++) begin
         int sel;
         int f;
         logic [7:0] v;
         sel = int'($urandom % 100);
         if (sel < 12) begin
            f = int'($urandom % 8);
            case (f)
               0: v = i2b(50 + int'($urandom % 10)) | (($urandom % 20 == 0) ? 8'h80 : 8'h00);
               1: v = i2b(55 + int'($urandom % 5));
               2: v = i2b(20 + int'($urandom % 4));
               3: v = i2b(1 + int'($urandom % 7));
               4: v = i2b(26 + int'($urandom % 6));
               5: v = i2b(1 + int'($urandom % 12));
               6: v = i2b(int'($urandom % 100));
               default: v = 8'($urandom);
            endcase
            step(($urandom % 2) == 1, 1, 3'(f), v);
         end else begin
            step(sel < 85, 0, 3'd0, 8'h00);
         end
      end

      finish_run();
   end
endmodule